// File: doc/BRIEF.md
# Two-Wire Bus Master Byte Engine

This block is a master for a two-wire serial bus (I2C). It turns byte-level requests into bus activity: a START condition, a 7-bit device address with a direction bit, an optional one-byte internal address, a run of data bytes with acknowledge bits, and a closing STOP. It drives both lines as open-drain outputs. An output that is high pulls the line low. An output that is low lets the external pull-up hold the line high. The serial clock runs at a fixed rate that is set by a parameter.

Software sets up the transfer on configuration inputs. It gives the device address, the direction, whether an internal-address byte is present and its value, and the read length. It then pulses a start command. On writes, software keeps a transmit holding register topped up. If the holding register is still empty when a byte is acknowledged, the engine ends the transfer with a STOP. On reads, each received byte lands in a receive holding register, and software takes it with a pop strobe. The engine acknowledges every read byte except the last. A not-acknowledge from the device aborts the transfer.

Each bus bit is split into four quarters of `QTR_CLKS` system clocks. SCL is low in quarters 0–1 and high in quarters 2–3. Data changes at the start of quarter 0, and SDA is sampled as SCL rises.

The states are IDLE, START, ADDR, IADR, WDATA, RDATA and STOP. The transitions are:
- IDLE→START on a start command.
- START→ADDR after one bit time.
- ADDR→RDATA on an acknowledged read address.
- ADDR→IADR on an acknowledged write address when the internal address is enabled and has not been sent yet.
- ADDR/IADR/WDATA→WDATA when the byte was acknowledged and a new byte is held.
- IADR→START, a repeated start, on reads.
- RDATA→RDATA while bytes remain.
- Any byte state→STOP on a not-acknowledge, an empty holding register or the last read byte.
- STOP→IDLE after one bit time.

Top module: `i2c_master_ctl`

## Requirements
- R1: After reset both line-drive outputs are 0 (released), `st_tx_ready`=1, and `st_rx_ready`, `st_nack` and `st_done` are all 0.
- R2: A start command in IDLE clears `st_nack` and `st_done` and produces a START (SDA falls while SCL is high). The address byte follows, MSB first, as the 7-bit device address then the direction bit (1 = read, 0 = write).
- R3: SDA changes only while SCL is low, except during START and STOP. Each SCL high phase of a data bit lasts 2×`QTR_CLKS` system clocks.
- R4: When the internal-address enable is set, its byte is sent after the acknowledged device address and before any data byte.
- R5: Writing the transmit holding register clears `st_tx_ready` on the next cycle. The flag sets again when the engine takes the byte for sending.
- R6: In a write, if a byte is acknowledged and no new byte is held, a STOP follows with no further command.
- R7: A read clocks in the programmed number of bytes (0 counts as 1). The master drives ACK (SDA low) after each byte except the last, which gets a NACK (released), and then a STOP.
- R8: A read with the internal address enabled sends the address with the direction bit 0, then the internal byte, then a repeated START, then the address with the direction bit 1.
- R9: `st_rx_ready` sets when a received byte enters the receive holding register and clears the cycle after `rx_pop`, unless a new byte arrives in that same cycle.
- R10: A NACK to any byte the master sends aborts the transfer with a STOP and sets both `st_nack` and `st_done`. A queued byte stays unsent.
- R11: `st_done` sets when STOP completes and holds only while idle. A start command during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe, accepted only in IDLE |
| cfg_dev | input | 7 | Device address |
| cfg_read | input | 1 | Direction: 1 read, 0 write |
| cfg_ia_en | input | 1 | Insert the internal-address byte |
| cfg_ia | input | 8 | Internal-address byte |
| cfg_rd_len | input | LEN_W | Number of bytes to read |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_byte | input | 8 | Byte to transmit |
| rx_pop | input | 1 | Read strobe for the receive holding register |
| rx_byte | output | 8 | Last received byte |
| st_tx_ready | output | 1 | Transmit holding register empty |
| st_rx_ready | output | 1 | Receive holding register full |
| st_nack | output | 1 | A sent byte was not acknowledged |
| st_done | output | 1 | The last transfer has finished its STOP |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions check on every cycle that SDA only moves while SCL is high inside START or STOP, and that both lines are released in IDLE. They also check that the two holding-register flags clear after a write or pop, that a start command clears the sticky flags, and that `st_done` is seen only while idle. Only the bench's scenarios can show the byte order on the wire: address, internal byte, repeated start, data. They also show the ACK/NACK pattern in reads, the automatic STOP when the transmit register runs dry, the abort on a device NACK, and the length of the SCL high phase. A bus-device model drives these scenarios and a scoreboard compares the results.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_IADR,
        S_WDATA,
        S_RDATA,
        S_STOP
    } state_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int QTR_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(QTR_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2cm_hold.sv
module i2cm_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic [W-1:0] dout,
    output logic         full
);
    // A load wins over a take in the same cycle, so no byte is lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
            full <= 1'b0;
        end else if (load) begin
            dout <= din;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_master_ctl.sv
module i2c_master_ctl
    import i2cm_pkg::*;
#(
    parameter int QTR_CLKS = 4,
    parameter int LEN_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [6:0]       cfg_dev,
    input  logic             cfg_read,
    input  logic             cfg_ia_en,
    input  logic [7:0]       cfg_ia,
    input  logic [LEN_W-1:0] cfg_rd_len,
    input  logic             tx_wr,
    input  logic [7:0]       tx_byte,
    input  logic             rx_pop,
    output logic [7:0]       rx_byte,
    output logic             st_tx_ready,
    output logic             st_rx_ready,
    output logic             st_nack,
    output logic             st_done,
    output logic             scl_low,
    output logic             sda_low,
    input  logic             sda_in
);
    localparam logic [3:0] ACK_BIT = 4'd8;
    localparam logic [3:0] LAST_RX = 4'd7;

    state_t           state, state_nx;
    logic [1:0]       q;
    logic [3:0]       bitn;
    logic [7:0]       shreg;
    logic [LEN_W-1:0] rem;
    logic [6:0]       dev_l;
    logic [7:0]       ia_l;
    logic             rd_l, ia_en_l, rs_done, ack_ok;
    logic             running, tick, bit_end, sample, is_send, byte_end, go;
    logic             tx_full, tx_take, rx_load, addr_rw;
    logic [7:0]       tx_q;

    assign running  = (state != S_IDLE);
    assign bit_end  = tick && (q == 2'd3);
    assign sample   = tick && (q == 2'd1);
    assign is_send  = (state == S_ADDR) || (state == S_IADR) || (state == S_WDATA);
    assign byte_end = bit_end && (bitn == ACK_BIT) && (is_send || state == S_RDATA);
    assign go       = cmd_start && (state == S_IDLE);
    assign addr_rw  = rd_l && (!ia_en_l || rs_done);
    assign tx_take  = byte_end && (state_nx == S_WDATA);
    assign rx_load  = (state == S_RDATA) && bit_end && (bitn == LAST_RX);
    assign st_tx_ready = !tx_full;

    i2cm_tick #(.QTR_CLKS(QTR_CLKS)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (running),
        .tick (tick)
    );

    i2cm_hold #(.W(8)) u_txh (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tx_wr),
        .din  (tx_byte),
        .take (tx_take),
        .dout (tx_q),
        .full (tx_full)
    );

    i2cm_hold #(.W(8)) u_rxh (
        .clk  (clk),
        .rst_n(rst_n),
        .load (rx_load),
        .din  (shreg),
        .take (rx_pop),
        .dout (rx_byte),
        .full (st_rx_ready)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (cmd_start) state_nx = S_START;
            S_START: if (bit_end)   state_nx = S_ADDR;
            S_ADDR: if (byte_end) begin
                if (!ack_ok)                    state_nx = S_STOP;
                else if (addr_rw)               state_nx = S_RDATA;
                else if (ia_en_l && !rs_done)   state_nx = S_IADR;
                else if (tx_full)               state_nx = S_WDATA;
                else                            state_nx = S_STOP;
            end
            S_IADR: if (byte_end) begin
                if (!ack_ok)      state_nx = S_STOP;
                else if (rd_l)    state_nx = S_START;
                else if (tx_full) state_nx = S_WDATA;
                else              state_nx = S_STOP;
            end
            S_WDATA: if (byte_end) state_nx = (ack_ok && tx_full) ? S_WDATA : S_STOP;
            S_RDATA: if (byte_end) state_nx = (rem == LEN_W'(1)) ? S_STOP : S_RDATA;
            S_STOP:  if (bit_end)  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            q       <= '0;
            bitn    <= '0;
            shreg   <= '0;
            rem     <= '0;
            dev_l   <= '0;
            ia_l    <= '0;
            rd_l    <= 1'b0;
            ia_en_l <= 1'b0;
            rs_done <= 1'b0;
            ack_ok  <= 1'b0;
            st_nack <= 1'b0;
            st_done <= 1'b0;
        end else begin
            state <= state_nx;
            if (tick)
                q <= q + 2'd1;
            if (bit_end)
                bitn <= (bitn == ACK_BIT || state == S_START || state == S_STOP)
                        ? '0 : bitn + 4'd1;
            if (go) begin
                dev_l   <= cfg_dev;
                rd_l    <= cfg_read;
                ia_en_l <= cfg_ia_en;
                ia_l    <= cfg_ia;
                rem     <= (cfg_rd_len == '0) ? LEN_W'(1) : cfg_rd_len;
                rs_done <= 1'b0;
                st_nack <= 1'b0;
                st_done <= 1'b0;
            end
            if (sample) begin
                if (state == S_RDATA) begin
                    if (bitn != ACK_BIT)
                        shreg <= {shreg[6:0], sda_in};
                end else if (is_send && bitn == ACK_BIT) begin
                    ack_ok <= !sda_in;
                end
            end
            if (state_nx == S_ADDR && state != S_ADDR)
                shreg <= {dev_l, addr_rw};
            else if (state_nx == S_IADR && state != S_IADR)
                shreg <= ia_l;
            else if (tx_take)
                shreg <= tx_q;
            if (state == S_IADR && state_nx == S_START)
                rs_done <= 1'b1;
            if (state == S_RDATA && byte_end)
                rem <= rem - LEN_W'(1);
            if (byte_end && is_send && !ack_ok)
                st_nack <= 1'b1;
            if (state == S_STOP && bit_end)
                st_done <= 1'b1;
        end
    end

    // Line drive per state and quarter
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (state)
            S_IDLE: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
            S_START: begin
                scl_low = (q == 2'd0) || (q == 2'd3);
                sda_low = q[1];
            end
            S_STOP: begin
                scl_low = (q == 2'd0);
                sda_low = !q[1];
            end
            S_RDATA: begin
                scl_low = !q[1];
                sda_low = (bitn == ACK_BIT) && (rem != LEN_W'(1));
            end
            default: begin
                scl_low = !q[1];
                sda_low = (bitn != ACK_BIT) && !shreg[~bitn[2:0]];
            end
        endcase
    end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk
    import i2cm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cmd_start,
    input logic   tx_wr,
    input logic   rx_pop,
    input logic   rx_load,
    input logic   st_tx_ready,
    input logic   st_rx_ready,
    input logic   st_nack,
    input logic   st_done,
    input logic   scl_low,
    input logic   sda_low,
    input state_t state
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE |-> (!scl_low && !sda_low));

    // R2
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && state == S_IDLE) |=> (!st_done && !st_nack));

    // R3
    sda_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && !$past(scl_low) && (sda_low != $past(sda_low)))
        |-> (state == S_START || state == S_STOP));

    // R5
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !st_tx_ready);

    // R9
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_load) |=> !st_rx_ready);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> state == S_IDLE);
endmodule

bind i2c_master_ctl i2cm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .tx_wr      (tx_wr),
    .rx_pop     (rx_pop),
    .rx_load    (rx_load),
    .st_tx_ready(st_tx_ready),
    .st_rx_ready(st_rx_ready),
    .st_nack    (st_nack),
    .st_done    (st_done),
    .scl_low    (scl_low),
    .sda_low    (sda_low),
    .state      (state)
);

// File: tb/sim_i2c_master_ctl.sv
module sim_i2c_master_ctl;
    localparam int QTR = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [6:0] cfg_dev = '0;
    logic       cfg_read = 1'b0;
    logic       cfg_ia_en = 1'b0;
    logic [7:0] cfg_ia = '0;
    logic [7:0] cfg_rd_len = '0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_byte;
    logic       st_tx_ready, st_rx_ready, st_nack, st_done;
    logic       scl_low, sda_low;
    logic       s_low = 1'b0;
    logic       sda_in;
    logic       scl_line;

    assign sda_in   = !(sda_low || s_low);
    assign scl_line = !scl_low;

    i2c_master_ctl #(.QTR_CLKS(QTR), .LEN_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
        .cfg_dev(cfg_dev), .cfg_read(cfg_read), .cfg_ia_en(cfg_ia_en),
        .cfg_ia(cfg_ia), .cfg_rd_len(cfg_rd_len),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_pop(rx_pop), .rx_byte(rx_byte),
        .st_tx_ready(st_tx_ready), .st_rx_ready(st_rx_ready),
        .st_nack(st_nack), .st_done(st_done),
        .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] b;
        string      req;
    } item_t;

    item_t exp_wire[$];
    bit    exp_mack[$];
    int    starts = 0, stops = 0, slave_bytes = 0, nack_at = -1;
    int    tcount = 0, last_hi = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_val(int k);
        return 8'h5A ^ 8'(k * 19);
    endfunction

    // Bus device model and wire-side scoreboard monitor
    initial begin
        bit ps = 1, pd = 1, sc, sd, act = 0, txm = 0, first = 0, addr_read = 0, mack = 0;
        int bitc = 0, hi_len = 0;
        logic [7:0] sh = '0, txb = '0;
        forever begin
            @(negedge clk);
            sc = scl_line;
            sd = sda_in;
            if (!ps && sc) hi_len = 1; else if (sc) hi_len++;
            if (ps && sc && pd && !sd) begin
                starts++; act = 1; bitc = 0; txm = 0; s_low = 0; first = 1;
            end else if (ps && sc && !pd && sd) begin
                stops++; act = 0; txm = 0; s_low = 0;
            end else if (act && !ps && sc) begin
                if (bitc < 8) begin
                    if (!txm) sh = {sh[6:0], sd};
                    bitc++;
                end else if (bitc == 8) begin
                    if (txm) begin
                        mack = !sd;
                        if (exp_mack.size() == 0) chk("R7", "unexpected master ack slot", 1, 0);
                        else chk("R7", "master ack bit", int'(mack), int'(exp_mack.pop_front()));
                    end
                    bitc = 9;
                end
            end else if (act && ps && !sc) begin
                last_hi = hi_len;
                if (bitc == 8) begin
                    if (!txm) begin
                        item_t it;
                        bit ack;
                        if (exp_wire.size() == 0) chk("R2", "unexpected wire byte", int'(sh), -1);
                        else begin
                            it = exp_wire.pop_front();
                            chk(it.req, "wire byte", int'(sh), int'(it.b));
                        end
                        ack = (slave_bytes != nack_at);
                        slave_bytes++;
                        s_low = ack;
                        addr_read = first && sh[0] && ack;
                        first = 0;
                    end else s_low = 0;
                end else if (bitc == 9) begin
                    bitc = 0; s_low = 0;
                    if (addr_read) begin txm = 1; addr_read = 0; end
                    else if (txm && !mack) txm = 0;
                    if (txm) begin txb = rd_val(tcount); tcount++; s_low = !txb[7]; end
                end else if (txm) begin
                    s_low = !txb[7 - bitc];
                end
            end
            ps = sc; pd = sd;
        end
    end

    task automatic push_tx(logic [7:0] b);
        @(negedge clk); tx_wr = 1; tx_byte = b;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic kick();
        @(negedge clk); cmd_start = 1;
        @(negedge clk); cmd_start = 0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!st_done && n < 20000) begin @(negedge clk); n++; end
        chk(req, "transfer finished in time", int'(n < 20000), 1);
    endtask

    task automatic expect_w(logic [7:0] b, string req);
        item_t it;
        it.b = b; it.req = req;
        exp_wire.push_back(it);
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        finish_sim();
    end

    initial begin
        int s0, p0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "scl_low", int'(scl_low), 0);
        chk("R1", "sda_low", int'(sda_low), 0);
        chk("R1", "tx_ready", int'(st_tx_ready), 1);
        chk("R1", "rx_ready", int'(st_rx_ready), 0);
        chk("R1", "nack", int'(st_nack), 0);
        chk("R1", "done", int'(st_done), 0);

        // Single-byte write, automatic STOP
        cfg_dev = 7'h50; cfg_read = 0; cfg_ia_en = 0;
        push_tx(8'h3C);
        chk("R5", "tx_ready after write", int'(st_tx_ready), 0);
        expect_w(8'hA0, "R2"); expect_w(8'h3C, "R6");
        s0 = starts; p0 = stops;
        kick();
        wait_done("R6");
        chk("R6", "stop count", stops - p0, 1);
        chk("R6", "all bytes seen", exp_wire.size(), 0);
        chk("R5", "tx_ready after take", int'(st_tx_ready), 1);
        chk("R10", "no nack", int'(st_nack), 0);
        chk("R3", "scl high length", last_hi, 2 * QTR);

        // Multi-byte write with internal address, start ignored mid-transfer
        cfg_ia_en = 1; cfg_ia = 8'h12;
        expect_w(8'hA0, "R2"); expect_w(8'h12, "R4");
        expect_w(8'h11, "R4"); expect_w(8'h22, "R5"); expect_w(8'h33, "R5");
        push_tx(8'h11);
        s0 = starts; p0 = stops;
        kick();
        for (int i = 0; i < 2; i++) begin
            while (!st_tx_ready) @(negedge clk);
            push_tx(i == 0 ? 8'h22 : 8'h33);
            if (i == 0) kick();
        end
        wait_done("R5");
        chk("R11", "one start only", starts - s0, 1);
        chk("R6", "one stop", stops - p0, 1);
        chk("R4", "all bytes seen", exp_wire.size(), 0);
        chk("R11", "done while idle", int'(st_done), 1);

        // Read three bytes
        cfg_dev = 7'h2B; cfg_read = 1; cfg_ia_en = 0; cfg_rd_len = 8'd3;
        tcount = 0;
        expect_w(8'h57, "R2");
        exp_mack.push_back(1); exp_mack.push_back(1); exp_mack.push_back(0);
        p0 = stops;
        kick();
        for (int i = 0; i < 3; i++) begin
            int n = 0;
            while (!st_rx_ready && n < 5000) begin @(negedge clk); n++; end
            chk("R9", "rx_ready set", int'(st_rx_ready), 1);
            chk("R7", "rx byte", int'(rx_byte), int'(rd_val(i)));
            rx_pop = 1; @(negedge clk); rx_pop = 0; @(negedge clk);
            chk("R9", "rx_ready cleared by pop", int'(st_rx_ready), 0);
        end
        wait_done("R7");
        chk("R7", "stop after last", stops - p0, 1);
        chk("R7", "ack pattern consumed", exp_mack.size(), 0);

        // Read with internal address, length 0 counts as 1
        cfg_dev = 7'h50; cfg_ia_en = 1; cfg_ia = 8'h7E; cfg_rd_len = 8'd0;
        tcount = 0;
        expect_w(8'hA0, "R8"); expect_w(8'h7E, "R8"); expect_w(8'hA1, "R8");
        exp_mack.push_back(0);
        s0 = starts;
        kick();
        wait_done("R8");
        chk("R8", "repeated start", starts - s0, 2);
        chk("R8", "wire bytes", exp_wire.size(), 0);
        chk("R7", "single byte nacked", exp_mack.size(), 0);
        chk("R7", "rx byte", int'(rx_byte), int'(rd_val(0)));
        rx_pop = 1; @(negedge clk); rx_pop = 0;

        // NACK on the address
        cfg_dev = 7'h33; cfg_read = 0; cfg_ia_en = 0;
        push_tx(8'h99);
        expect_w(8'h66, "R10");
        nack_at = slave_bytes;
        p0 = stops;
        kick();
        wait_done("R10");
        chk("R10", "nack flag", int'(st_nack), 1);
        chk("R10", "stop after nack", stops - p0, 1);
        chk("R10", "byte not taken", int'(st_tx_ready), 0);

        // NACK on a data byte, the queued byte stays unsent
        cfg_dev = 7'h50;
        push_tx(8'h44);
        expect_w(8'hA0, "R10"); expect_w(8'h44, "R10");
        nack_at = slave_bytes + 1;
        kick();
        while (!st_tx_ready) @(negedge clk);
        push_tx(8'h55);
        wait_done("R10");
        chk("R10", "nack flag data", int'(st_nack), 1);
        chk("R10", "queued byte unsent", int'(st_tx_ready), 0);
        chk("R10", "no extra bytes", exp_wire.size(), 0);

        // Restart clears the flags and sends the held byte
        nack_at = -1;
        expect_w(8'hA0, "R2"); expect_w(8'h55, "R6");
        kick();
        chk("R2", "nack cleared", int'(st_nack), 0);
        chk("R2", "done cleared", int'(st_done), 0);
        wait_done("R2");
        chk("R2", "clean finish", int'(st_nack), 0);
        chk("R2", "wire bytes", exp_wire.size(), 0);

        repeat (10) @(negedge clk);
        finish_sim();
    end
endmodule